// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one W-bit integer by another over several clock cycles and produces one quotient bit per cycle. The dividend goes into the low half of a shared shift register whose upper half holds the partial remainder. In each step the block subtracts the divisor from the upper half. A non-negative difference is kept and a 1 is shifted in. A negative difference leaves the previous upper half in place and a 0 is shifted in. The quotient builds up in the low half of the same register. The register is shifted once before the loop, so the remainder ends one place too far left. A final right shift of the upper half alone puts it back.

The host pulses `start` with the operands and the mode select while the block is idle. `busy` then rises. A one-cycle `done` pulse marks valid results, which stay on the outputs until the next operation completes. In signed mode the operands are first turned into magnitudes and run through the same unsigned core. Afterwards the quotient is negated when the operand signs differ, and the remainder takes the sign of the dividend. A zero divisor raises a flag together with `done` after the usual number of cycles. The quotient and remainder for that case carry no defined meaning.

Top module: `int_divider`

## Requirements
- R1: In unsigned mode (`signed_mode` = 0) the outputs satisfy dividend = quotient * divisor + remainder with remainder < divisor, for every non-zero divisor.
- R2: `done` rises on the (W+3)-th rising edge when the edge that samples an accepted `start` is counted as the first: one load cycle, one pre-shift cycle, W iteration cycles and one result cycle.
- R3: `busy` is 0 in the cycle before an accepted `start` and is 1 from the next cycle until `done` is asserted. `done` is high for exactly one cycle, and `busy` is 0 while it is high.
- R4: `quotient`, `remainder` and `div_by_zero` hold their values in every cycle in which `done` is low.
- R5: A `start` pulse that arrives while `busy` is 1 is ignored. It produces no extra `done`, and it does not change the result of the operation in progress.
- R6: In signed mode (`signed_mode` = 1, two's complement operands) the quotient is truncated toward zero. It is negative when exactly one operand is negative, for example -7 / 2 gives -3.
- R7: In signed mode the remainder is zero or has the sign of the dividend, for example -7 / 2 gives remainder -1 and 7 / -2 gives remainder +1.
- R8: `signed_mode` is sampled with each accepted `start`, so the same bit pattern divides differently per mode. In signed mode the most negative value divided by -1 wraps to the most negative value with remainder 0.
- R9: A zero divisor sets `div_by_zero` to 1 in the `done` cycle, and the latency is the same as for any other operand. Any non-zero divisor leaves it 0.
- R10: After a synchronous reset, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all 0.
- R11: The full operand range is handled. A divisor with its top bit set combined with a dividend of all ones gives correct results in unsigned mode.
- R12: A `start` asserted in the `done` cycle is accepted, and that operation completes with its own results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; taken only when not busy |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | W | Dividend, sampled with an accepted start |
| divisor | input | W | Divisor, sampled with an accepted start |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: results valid |
| quotient | output | W | Quotient of the last completed operation |
| remainder | output | W | Remainder of the last completed operation |
| div_by_zero | output | 1 | Last completed operation had a zero divisor |

## Verification
The completion pulse of one division and the acceptance of the next `start` can fall in the same cycle, because `busy` is already low while `done` is high. The bench provokes this by driving the next `start` at the very falling edge where it sees `done`. Each division is therefore issued back to back with the previous one. The scoreboard then checks two things. The first operation's results are still on the outputs in that shared cycle. The second operation completes after exactly W+3 edges with its own quotient and remainder. A start raised in the middle of a busy period is judged separately: the count of `done` pulses must equal the number of queued expectations, and the result must belong to the earlier operands.

// File: rtl/div_pkg.sv
package div_pkg;

    // Sequencer states of the shared-register divider core
    typedef enum logic [1:0] {
        CS_IDLE     = 2'd0,
        CS_PRESHIFT = 2'd1,
        CS_ITER     = 2'd2,
        CS_FIX      = 2'd3
    } core_state_t;

    // Sign bookkeeping captured with an accepted start
    typedef struct packed {
        logic neg_quot;
        logic neg_rem;
        logic zero_div;
    } sign_info_t;

    localparam sign_info_t SIGN_INFO_CLEAR = '{neg_quot: 1'b0, neg_rem: 1'b0, zero_div: 1'b0};

endpackage

// File: rtl/div_sign_prep.sv
module div_sign_prep
    import div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         signed_mode,
    input  logic [W-1:0] num_in,
    input  logic [W-1:0] den_in,
    output logic [W-1:0] num_mag,
    output logic [W-1:0] den_mag,
    output sign_info_t   info
);
    logic num_neg;
    logic den_neg;

    always_comb begin
        num_neg       = signed_mode & num_in[W-1];
        den_neg       = signed_mode & den_in[W-1];
        num_mag       = num_neg ? (~num_in + 1'b1) : num_in;
        den_mag       = den_neg ? (~den_in + 1'b1) : den_in;
        info.neg_quot = num_neg ^ den_neg;
        info.neg_rem  = num_neg;
        info.zero_div = (den_in == '0);
    end

    // Unsigned mode passes operands through untouched
    always_comb begin
        if (!signed_mode) begin
            AST_UNSIGNED_PASS: assert (num_mag == num_in && den_mag == den_in); // R1
        end
    end

endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix
    import div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] quot_mag,
    input  logic [W-1:0] rem_mag,
    input  sign_info_t   info,
    output logic [W-1:0] quot_out,
    output logic [W-1:0] rem_out
);
    always_comb begin
        quot_out = info.neg_quot ? (~quot_mag + 1'b1) : quot_mag;
        rem_out  = info.neg_rem  ? (~rem_mag  + 1'b1) : rem_mag;
    end

endmodule

// File: rtl/div_core.sv
module div_core
    import div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num_mag,
    input  logic [W-1:0] den_mag,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] quot_raw,
    output logic [W-1:0] rem_raw
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    core_state_t   state;
    logic [W:0]    hi;       // partial remainder, one guard bit
    logic [W-1:0]  lo;       // dividend bits out, quotient bits in
    logic [W-1:0]  den;
    logic [CW-1:0] step;

    logic [W+1:0]  diff;
    logic          take;
    logic [W:0]    hi_kept;

    always_comb begin
        diff    = {1'b0, hi} - {2'b00, den};
        take    = ~diff[W+1];
        hi_kept = take ? diff[W:0] : hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CS_IDLE;
            hi    <= '0;
            lo    <= '0;
            den   <= '0;
            step  <= '0;
        end else begin
            unique case (state)
                CS_IDLE: begin
                    if (go) begin
                        hi    <= '0;
                        lo    <= num_mag;
                        den   <= den_mag;
                        state <= CS_PRESHIFT;
                    end
                end
                CS_PRESHIFT: begin
                    {hi, lo} <= {hi[W-1:0], lo, 1'b0};
                    step     <= '0;
                    state    <= CS_ITER;
                end
                CS_ITER: begin
                    {hi, lo} <= {hi_kept[W-1:0], lo, take};
                    step     <= step + 1'b1;
                    if (step == LAST_STEP) begin
                        state <= CS_FIX;
                    end
                end
                CS_FIX: begin
                    state <= CS_IDLE;
                end
                default: state <= CS_IDLE;
            endcase
        end
    end

    // Final correction: upper half moved right one place, low half is the quotient
    assign busy     = (state != CS_IDLE);
    assign fin      = (state == CS_FIX);
    assign quot_raw = lo;
    assign rem_raw  = hi[W:1];

    AST_PRESHIFT_ONCE: assert property (@(posedge clk) disable iff (rst)
        state == CS_PRESHIFT |=> state == CS_ITER && step == '0); // R2

    AST_LOOP_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (state == CS_ITER && step == LAST_STEP) |=> state == CS_FIX); // R2

    AST_KEPT_FITS: assert property (@(posedge clk) disable iff (rst)
        state == CS_ITER |-> !hi_kept[W]); // R11

    AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
        (fin && den != '0) |-> rem_raw < den); // R1

    AST_DEN_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(den)); // R5

endmodule

// File: rtl/int_divider.sv
module int_divider
    import div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero
);
    logic [W-1:0] num_mag;
    logic [W-1:0] den_mag;
    sign_info_t   info_now;
    sign_info_t   info_q;
    logic         core_busy;
    logic         core_fin;
    logic         go;
    logic [W-1:0] quot_raw;
    logic [W-1:0] rem_raw;
    logic [W-1:0] quot_fix;
    logic [W-1:0] rem_fix;

    assign go   = start & ~core_busy;
    assign busy = core_busy;

    div_sign_prep #(.W(W)) u_prep (
        .signed_mode (signed_mode),
        .num_in      (dividend),
        .den_in      (divisor),
        .num_mag     (num_mag),
        .den_mag     (den_mag),
        .info        (info_now)
    );

    div_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .num_mag  (num_mag),
        .den_mag  (den_mag),
        .busy     (core_busy),
        .fin      (core_fin),
        .quot_raw (quot_raw),
        .rem_raw  (rem_raw)
    );

    div_sign_fix #(.W(W)) u_fix (
        .quot_mag (quot_raw),
        .rem_mag  (rem_raw),
        .info     (info_q),
        .quot_out (quot_fix),
        .rem_out  (rem_fix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            info_q      <= SIGN_INFO_CLEAR;
            done        <= 1'b0;
            quotient    <= '0;
            remainder   <= '0;
            div_by_zero <= 1'b0;
        end else begin
            if (go) begin
                info_q <= info_now;
            end
            done <= core_fin;
            if (core_fin) begin
                quotient    <= quot_fix;
                remainder   <= rem_fix;
                div_by_zero <= info_q.zero_div;
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R3

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R3

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R3

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(quotient) && $stable(remainder) && $stable(div_by_zero)); // R4

endmodule

// File: tb/int_divider_test.sv
module int_divider_test;
    localparam int W = 16;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic         dz;
        bit           chk_qr;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_by_zero;
    logic [W-1:0] quotient, remainder;

    int    total = 0;
    int    bad = 0;
    int    done_cnt = 0;
    int    pushed = 0;
    bit    finished = 0;
    exp_t  exp_q[$];
    logic [W-1:0] last_q, last_r;

    always #2.5 clk = ~clk;   // 200 MHz

    int_divider #(.W(W)) uut (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder), .div_by_zero(div_by_zero)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (!rst && done) begin
            done_cnt++;
            if (exp_q.size() == 0) begin
                chk(0, "R5", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(div_by_zero == e.dz, e.tag, "div_by_zero", div_by_zero, e.dz);
                chk(busy == 1'b0, "R3", "busy during done", busy, 0);
                if (e.chk_qr) begin
                    chk(quotient == e.q, e.tag, "quotient", quotient, e.q);
                    chk(remainder == e.r, e.tag, "remainder", remainder, e.r);
                end
                last_q = quotient;
                last_r = remainder;
            end
        end
    end

    // Driver: compute expectation, issue start, measure latency
    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                           input bit sgn, input string tag, input bit intrude);
        exp_t e;
        int   lat;
        e.tag = tag;
        e.dz = (b == '0);
        e.chk_qr = (b != '0);
        if (b != '0) begin
            if (sgn) begin
                int sa, sb, qi, ri;
                sa = $signed(a);
                sb = $signed(b);
                qi = sa / sb;
                ri = sa % sb;
                e.q = qi[W-1:0];
                e.r = ri[W-1:0];
            end else begin
                int ua, ub, qi, ri;
                ua = int'(a);
                ub = int'(b);
                qi = ua / ub;
                ri = ua % ub;
                e.q = qi[W-1:0];
                e.r = ri[W-1:0];
            end
        end else begin
            e.q = '0;
            e.r = '0;
        end
        exp_q.push_back(e);
        pushed++;
        chk(busy == 1'b0, "R3", "busy before start", busy, 0);
        start = 1'b1;
        signed_mode = sgn;
        dividend = a;
        divisor = b;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            if (lat == 1) chk(busy == 1'b1, "R3", "busy after start", busy, 1);
            if (intrude && lat == 4) begin
                start = 1'b1;           // R5: ignored while busy
                signed_mode = ~sgn;
                dividend = 16'h1234;
                divisor = 16'h0003;
            end
        end while (!done && lat < 200);
        chk(lat == W + 3, "R2", "latency", lat, W + 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && div_by_zero == 0, "R10", "reset flags",
            {busy, done, div_by_zero}, 0);
        chk(quotient == 0 && remainder == 0, "R10", "reset data",
            {quotient, remainder}, 0);

        run_div(16'd7, 16'd2, 0, "R1", 0);
        run_div(16'd1000, 16'd7, 0, "R1", 0);
        run_div(16'd5, 16'd9, 0, "R1", 0);
        run_div(16'hFFFF, 16'hFFFF, 0, "R11", 0);
        run_div(16'hFFFF, 16'h8001, 0, "R11", 0);
        run_div(16'hFFFE, 16'h8000, 0, "R11", 0);
        run_div(16'hFFFF, 16'd1, 0, "R11", 0);
        run_div(-16'sd7, 16'sd2, 1, "R6 R7", 0);
        run_div(16'sd7, -16'sd2, 1, "R6 R7", 0);
        run_div(-16'sd7, -16'sd2, 1, "R6 R7", 0);
        run_div(16'h0000, -16'sd5, 1, "R7", 0);
        run_div(16'hFFF9, 16'd2, 0, "R8", 0);
        run_div(16'hFFF9, 16'd2, 1, "R8", 0);
        run_div(16'h8000, 16'hFFFF, 1, "R8", 0);
        run_div(16'd77, 16'd0, 0, "R9", 0);
        run_div(-16'sd77, 16'd0, 1, "R9", 0);
        run_div(16'd500, 16'd3, 0, "R5", 1);

        // R4: outputs held while idle
        repeat (6) @(negedge clk);
        chk(quotient == last_q, "R4", "quotient held", quotient, last_q);
        chk(remainder == last_r, "R4", "remainder held", remainder, last_r);

        // R12: back-to-back runs, next start in each done cycle
        begin
            logic [W-1:0] s = 16'hACE1;
            for (int i = 0; i < 24; i++) begin
                logic [W-1:0] a, b;
                s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
                a = s;
                s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
                b = (i % 3 == 0) ? (s >> 8) : s;
                if (b == 0) b = 16'd1;
                run_div(a, b, i[0], "R12", 0);
            end
        end

        repeat (4) @(negedge clk);
        chk(done_cnt == pushed, "R5", "done count", done_cnt, pushed);
        chk(exp_q.size() == 0, "R5", "pending results", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule